// File: doc/BRIEF.md
# Cycle-Steal Memory Arbiter

This block shares one single-port synchronous memory between a CPU and a set of I/O requesters. No requester takes the port for a burst. Each granted request takes exactly one memory cycle from the CPU and moves one word, either a read or a write. During that cycle the arbiter drops the CPU clock enable, so the CPU stands still for that one cycle and then carries on. The CPU program therefore runs alongside any number of outstanding device operations, and steals from different devices interleave with each other and with CPU cycles.

When no device is asking, the memory port is wired straight to the CPU request, address and data, with no added cycle. When several devices ask in the same cycle, the lowest index wins. At least one CPU cycle always follows each stolen cycle, so continuous device traffic cannot starve the CPU. A counter of stolen cycles is available on a status output.

Top module: `cyc_steal_arb`

## Requirements
- R1: In a cycle with no steal, `cpu_ce` is 1 and a CPU access is performed in that same cycle. A write (`cpu_we`=1) stores `cpu_wdata` at `cpu_addr`. A read (`cpu_we`=0) shows the stored word on `cpu_rdata` from the next cycle on, and `cpu_rdata` keeps that value until the next CPU read is performed.
- R2: In a steal cycle, `cpu_ce` is 0 for exactly that cycle, and the CPU request in that cycle has no effect on the memory or on `cpu_rdata`.
- R3: A steal grants exactly one requester. `dev_gnt` is one-hot, lasts one cycle, and goes to the lowest-index requester whose `dev_req` bit is set.
- R4: Two steals never occur in adjacent cycles. In the cycle after a steal, `dev_gnt` is all zero and `cpu_ce` is 1, even if requests are pending.
- R5: A granted write (`dev_we[i]`=1) stores word i of `dev_wdata` at word i of `dev_addr`.
- R6: After a granted read by requester i, word i of `dev_rdata` carries the stored word from the cycle after the grant until that requester's next granted read. The other requesters' words do not change.
- R7: `steal_count` rises by one per stolen cycle, stays unchanged in other cycles, and saturates at all ones.
- R8: After reset, with no requests pending, `cpu_ce` is 1, `dev_gnt` is zero, `steal_count` is zero, and all read data outputs are zero.
- R9: When requesters hold their requests until granted, all of them are served. If all are pending at once, they are served in ascending index order, one steal every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU memory access request |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data, valid the cycle after the read |
| cpu_ce | output | 1 | CPU clock enable, 0 during a stolen cycle |
| dev_req | input | NREQ | Per-requester request, held until granted |
| dev_we | input | NREQ | Per-requester write (1) or read (0) |
| dev_addr | input | NREQ*AW | Per-requester word address, requester i at bits [i*AW +: AW] |
| dev_wdata | input | NREQ*DW | Per-requester write data, requester i at bits [i*DW +: DW] |
| dev_gnt | output | NREQ | One-cycle grant pulse |
| dev_rdata | output | NREQ*DW | Per-requester read data, requester i at bits [i*DW +: DW] |
| steal_count | output | STAT_W | Saturating count of stolen cycles |

## Verification
The hardest case to reach from the ports is the enforced gap after a steal. All requesters must be waiting at the same moment, so that a pending request is refused for one cycle and the winners come out in a strict every-other-cycle order. A directed section drains the random traffic, raises every request in a single cycle and follows the grant pattern cycle by cycle. Random traffic at a high request rate also keeps requests waiting through the gap. Saturation of the counter is reached with a narrow counter width on the bench instance and then checked directly.

// File: rtl/cs_pkg.sv
package cs_pkg;
   typedef enum logic {
      ACC_RD = 1'b0,
      ACC_WR = 1'b1
   } acc_e;
endpackage

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
   parameter int NREQ = 4
) (
   input  logic [NREQ-1:0] req,
   output logic [NREQ-1:0] pick
);
   // below[i] is set when any lower-index request is active
   logic [NREQ:0] below;
   assign below[0] = 1'b0;

   for (genvar i = 0; i < NREQ; i++) begin : g_chain
      assign pick[i]    = req[i] & ~below[i];
      assign below[i+1] = below[i] | req[i];
   end
endmodule

// File: rtl/cs_steal_ctl.sv
module cs_steal_ctl #(
   parameter int STAT_W   = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any_req,
   output logic              steal,
   output logic [STAT_W-1:0] count
);
   localparam logic [STAT_W-1:0] CNT_MAX = {STAT_W{1'b1}};

   logic              stole_q;
   logic [STAT_W-1:0] cnt_q;

   assign steal = any_req & ~stole_q;
   assign count = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) stole_q <= 1'b0;
      else        stole_q <= steal;
   end

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n)                       cnt_q <= '0;
         else if (steal && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)     cnt_q <= '0;
         else if (steal) cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4: a steal is always followed by a CPU cycle
   a_r4_gap_after_steal: assert property (@(posedge clk) disable iff (!rst_n)
      steal |=> !steal);

   // R7: one increment per stolen cycle below the ceiling
   a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (steal && count != CNT_MAX) |=> count == $past(count) + 1'b1);

   // R7: no stolen cycle, no change
   a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !steal |=> $stable(count));
endmodule

// File: rtl/cs_port_mem.sv
module cs_port_mem
   import cs_pkg::*;
#(
   parameter int NREQ = 4,
   parameter int AW   = 8,
   parameter int DW   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  acc_e               op,
   input  logic [AW-1:0]      addr,
   input  logic [DW-1:0]      wdata,
   input  logic [NREQ:0]      cap,     // [NREQ] CPU, [i] requester i
   output logic [DW-1:0]      cpu_q,
   output logic [NREQ*DW-1:0] dev_q
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];
   logic          rd_now;

   assign rd_now = en && (op == ACC_RD);

   always_ff @(posedge clk) begin
      if (en && op == ACC_WR) mem[addr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                cpu_q <= '0;
      else if (rd_now && cap[NREQ]) cpu_q <= mem[addr];
   end

   for (genvar i = 0; i < NREQ; i++) begin : g_devq
      always_ff @(posedge clk) begin
         if (!rst_n)                dev_q[i*DW +: DW] <= '0;
         else if (rd_now && cap[i]) dev_q[i*DW +: DW] <= mem[addr];
      end
   end

   // R3: the memory serves exactly one party per enabled cycle
   a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> $onehot(cap));
endmodule

// File: rtl/cyc_steal_arb.sv
module cyc_steal_arb
   import cs_pkg::*;
#(
   parameter int NREQ     = 4,
   parameter int AW       = 8,
   parameter int DW       = 16,
   parameter int STAT_W   = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [AW-1:0]      cpu_addr,
   input  logic [DW-1:0]      cpu_wdata,
   output logic [DW-1:0]      cpu_rdata,
   output logic               cpu_ce,
   input  logic [NREQ-1:0]    dev_req,
   input  logic [NREQ-1:0]    dev_we,
   input  logic [NREQ*AW-1:0] dev_addr,
   input  logic [NREQ*DW-1:0] dev_wdata,
   output logic [NREQ-1:0]    dev_gnt,
   output logic [NREQ*DW-1:0] dev_rdata,
   output logic [STAT_W-1:0]  steal_count
);
   if (NREQ < 1) begin : g_bad_nreq
      $error("cyc_steal_arb: NREQ must be at least 1");
   end
   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("cyc_steal_arb: AW must be 1..16");
   end
   if (DW < 1) begin : g_bad_dw
      $error("cyc_steal_arb: DW must be at least 1");
   end
   if (STAT_W < 2) begin : g_bad_stat
      $error("cyc_steal_arb: STAT_W must be at least 2");
   end

   logic            steal;
   logic [NREQ-1:0] pick;
   logic [AW-1:0]   m_addr;
   logic [DW-1:0]   m_wdata;
   logic            m_wr;
   acc_e            m_op;
   logic            m_en;
   logic [NREQ:0]   m_cap;

   cs_prio_pick #(.NREQ(NREQ)) u_pick (
      .req  (dev_req),
      .pick (pick)
   );

   cs_steal_ctl #(.STAT_W(STAT_W), .SATURATE(SATURATE)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .any_req (|dev_req),
      .steal   (steal),
      .count   (steal_count)
   );

   assign dev_gnt = {NREQ{steal}} & pick;
   assign cpu_ce  = ~steal;

   // port mux: CPU passes straight through unless a cycle is stolen
   always_comb begin
      m_addr  = cpu_addr;
      m_wdata = cpu_wdata;
      m_wr    = cpu_we;
      if (steal) begin
         m_addr  = '0;
         m_wdata = '0;
         m_wr    = 1'b0;
         for (int i = 0; i < NREQ; i++) begin
            if (pick[i]) begin
               m_addr  = m_addr  | dev_addr[i*AW +: AW];
               m_wdata = m_wdata | dev_wdata[i*DW +: DW];
               m_wr    = m_wr    | dev_we[i];
            end
         end
      end
   end

   assign m_op  = acc_e'(m_wr);
   assign m_en  = steal | cpu_req;
   assign m_cap = {~steal & cpu_req, dev_gnt};

   cs_port_mem #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (m_en),
      .op    (m_op),
      .addr  (m_addr),
      .wdata (m_wdata),
      .cap   (m_cap),
      .cpu_q (cpu_rdata),
      .dev_q (dev_rdata)
   );

   // R3: at most one grant at a time
   a_r3_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_gnt));

   // R3: a grant only goes to a requester that is asking
   a_r3_gnt_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_gnt & ~dev_req) == '0);

   // R2: CPU is stalled exactly in the granted cycles
   a_r2_ce_vs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ce == !(|dev_gnt));

   // R4: a grant is followed by a CPU cycle with no grant
   a_r4_gnt_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (|dev_gnt) |=> (cpu_ce && dev_gnt == '0));

   // R9: a waiting request is never skipped for two cycles in a row
   a_r9_no_idle_wait: assert property (@(posedge clk) disable iff (!rst_n)
      ((|dev_req) && !(|dev_gnt)) |=> (|dev_gnt) || !(|dev_req));
endmodule

// File: tb/cyc_steal_arb_test.sv
module cyc_steal_arb_test;
   localparam int NREQ   = 4;
   localparam int AW     = 6;
   localparam int DW     = 16;
   localparam int STAT_W = 8;
   localparam int DEPTH  = 1 << AW;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               cpu_req, cpu_we;
   logic [AW-1:0]      cpu_addr;
   logic [DW-1:0]      cpu_wdata, cpu_rdata;
   logic               cpu_ce;
   logic [NREQ-1:0]    dev_req, dev_we, dev_gnt;
   logic [NREQ*AW-1:0] dev_addr;
   logic [NREQ*DW-1:0] dev_wdata, dev_rdata;
   logic [STAT_W-1:0]  steal_count;

   always #5 clk = ~clk;

   cyc_steal_arb #(.NREQ(NREQ), .AW(AW), .DW(DW), .STAT_W(STAT_W), .SATURATE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ce(cpu_ce),
      .dev_req(dev_req), .dev_we(dev_we), .dev_addr(dev_addr),
      .dev_wdata(dev_wdata), .dev_gnt(dev_gnt), .dev_rdata(dev_rdata),
      .steal_count(steal_count)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // bench model
   logic [DW-1:0]     mem_m [DEPTH];
   logic [DW-1:0]     cpu_rd_m;
   logic [DW-1:0]     dev_rd_m [NREQ];
   logic              stole_m;
   logic [STAT_W-1:0] cnt_m;
   logic [NREQ-1:0]   pend;
   logic              p_we   [NREQ];
   logic [AW-1:0]     p_addr [NREQ];
   logic [DW-1:0]     p_data [NREQ];
   logic [NREQ-1:0]   last_gnt;
   bit                cpu_rand;
   logic              c_req, c_we;
   logic [AW-1:0]     c_addr;
   logic [DW-1:0]     c_data;

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
      end
   endtask

   function automatic logic [NREQ-1:0] exp_gnt(input logic [NREQ-1:0] r, input logic stole);
      exp_gnt = '0;
      if (!stole) begin
         for (int i = NREQ-1; i >= 0; i--) if (r[i]) exp_gnt = NREQ'(1) << i;
      end
   endfunction

   function automatic logic [STAT_W-1:0] next_cnt(input logic [STAT_W-1:0] c);
      next_cnt = (c == {STAT_W{1'b1}}) ? c : c + 1'b1;
   endfunction

   // one clock of stimulus and checking; rate = new-request chance in percent
   task automatic step(input int rate);
      logic [NREQ-1:0] eg;
      @(negedge clk);
      chk(cpu_rdata == cpu_rd_m, "R1 cpu_rdata", cpu_rdata, cpu_rd_m);
      for (int i = 0; i < NREQ; i++)
         chk(dev_rdata[i*DW +: DW] == dev_rd_m[i], "R6 dev_rdata", dev_rdata[i*DW +: DW], dev_rd_m[i]);
      chk(steal_count == cnt_m, "R7 steal_count", steal_count, cnt_m);
      for (int i = 0; i < NREQ; i++) begin
         if (!pend[i] && int'($urandom % 100) < rate) begin
            pend[i]   = 1'b1;
            p_we[i]   = 1'($urandom);
            p_addr[i] = AW'($urandom);
            p_data[i] = DW'($urandom);
         end
      end
      for (int i = 0; i < NREQ; i++) begin
         dev_req[i]              = pend[i];
         dev_we[i]               = p_we[i];
         dev_addr[i*AW +: AW]    = p_addr[i];
         dev_wdata[i*DW +: DW]   = p_data[i];
      end
      if (cpu_rand) begin
         c_req  = 1'($urandom);
         c_we   = 1'($urandom);
         c_addr = AW'($urandom);
         c_data = DW'($urandom);
      end
      cpu_req = c_req; cpu_we = c_we; cpu_addr = c_addr; cpu_wdata = c_data;
      #1;
      eg = exp_gnt(pend, stole_m);
      last_gnt = dev_gnt;
      chk(dev_gnt == eg, stole_m ? "R4 dev_gnt" : "R3 dev_gnt", dev_gnt, eg);
      chk(cpu_ce == (eg == '0), (eg != '0) ? "R2 cpu_ce" : "R1 cpu_ce", cpu_ce, (eg == '0));
      // model the coming edge
      if (eg != '0) begin
         for (int i = 0; i < NREQ; i++) begin
            if (eg[i]) begin
               if (p_we[i]) mem_m[p_addr[i]] = p_data[i];   // R5
               else         dev_rd_m[i] = mem_m[p_addr[i]]; // R6
               pend[i] = 1'b0;
            end
         end
         stole_m = 1'b1;
         cnt_m   = next_cnt(cnt_m);
      end else begin
         stole_m = 1'b0;
         if (c_req) begin
            if (c_we) mem_m[c_addr] = c_data;
            else      cpu_rd_m = mem_m[c_addr];
         end
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5150));
      rst_n = 1'b0;
      cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
      dev_req = '0; dev_we = '0; dev_addr = '0; dev_wdata = '0;
      pend = '0; stole_m = 1'b0; cnt_m = '0; cpu_rd_m = '0; cpu_rand = 1'b0;
      c_req = 1'b0; c_we = 1'b0; c_addr = '0; c_data = '0;
      for (int i = 0; i < NREQ; i++) begin
         dev_rd_m[i] = '0; p_we[i] = 1'b0; p_addr[i] = '0; p_data[i] = '0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R8: reset state
      #1;
      chk(cpu_ce == 1'b1, "R8 cpu_ce", cpu_ce, 1);
      chk(dev_gnt == '0, "R8 dev_gnt", dev_gnt, 0);
      chk(steal_count == '0, "R8 steal_count", steal_count, 0);
      chk(cpu_rdata == '0 && dev_rdata == '0, "R8 rdata", cpu_rdata, 0);

      // R1: CPU fills the memory, no device traffic
      for (int a = 0; a < DEPTH; a++) begin
         c_req = 1'b1; c_we = 1'b1; c_addr = AW'(a); c_data = DW'(a * 97 + 3);
         step(0);
      end
      // R1: CPU reads back a few words
      for (int a = 0; a < 8; a++) begin
         c_req = 1'b1; c_we = 1'b0; c_addr = AW'(a * 7);
         step(0);
      end

      // R2: CPU write held during a steal must not land
      pend[2] = 1'b1; p_we[2] = 1'b0; p_addr[2] = 6'd9;
      c_req = 1'b1; c_we = 1'b1; c_addr = 6'd9; c_data = 16'hDEAD;
      step(0);   // steal: CPU write ignored, device reads old word
      chk(last_gnt == 4'b0100, "R2 steal taken", last_gnt, 4'b0100);
      c_req = 1'b1; c_we = 1'b0; c_addr = 6'd9;
      step(0);   // CPU read of the word
      c_req = 1'b0;
      step(0);
      chk(cpu_rdata == DW'(9 * 97 + 3), "R2 word untouched", cpu_rdata, 9 * 97 + 3);

      // random mixed traffic (R1..R7)
      cpu_rand = 1'b1;
      for (int k = 0; k < 3000; k++) step((k / 500) % 2 == 0 ? 30 : 90);

      // R9: drain, then all requesters at once
      cpu_rand = 1'b0; c_req = 1'b0;
      for (int k = 0; k < 12; k++) step(0);
      for (int i = 0; i < NREQ; i++) begin
         pend[i] = 1'b1; p_we[i] = 1'b0; p_addr[i] = AW'(i + 20);
      end
      for (int k = 0; k < 2 * NREQ; k++) begin
         step(0);
         if (k % 2 == 0)
            chk(last_gnt == NREQ'(1) << (k / 2), "R9 order", last_gnt, NREQ'(1) << (k / 2));
         else
            chk(last_gnt == '0, "R9 gap", last_gnt, 0);
      end
      step(0);

      // R7: counter saturation (narrow counter on this instance)
      for (int k = 0; k < 40; k++) begin
         pend[k % NREQ] = 1'b1; p_we[k % NREQ] = 1'b1;
         p_addr[k % NREQ] = AW'(k); p_data[k % NREQ] = DW'(k);
         step(0);
      end
      chk(steal_count == {STAT_W{1'b1}}, "R7 saturated", steal_count, {STAT_W{1'b1}});

      // R5: read back device writes through the CPU
      for (int a = 0; a < 16; a++) begin
         c_req = 1'b1; c_we = 1'b0; c_addr = AW'(a);
         step(0);
      end
      c_req = 1'b0;
      step(0);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule